// File: doc/BRIEF.md
# Phase-Sweep Path Delay Digitizer

This block turns the propagation delay of one combinational path into an integer. It runs a series of launch-capture tests against the path. Each test first drives an initial value into the path through a launch register. After the path has settled, the launch register is loaded with the opposite value, so the path makes one transition. A capture register runs on a second clock and samples the path output. An external clock manager shifts the phase of that second clock.

Between failing tests, the controller asks the clock manager for one fine phase step (roughly 18 ps each). It waits for the step to be acknowledged before it launches again. The first step index at which the captured bit equals the final launched value is reported as the delay. If the sweep reaches a programmable step limit without a match, the result is flagged as a timeout. After every result, the capture phase is returned to step zero, ready for the next path. Rising and falling transitions are measured in separate runs, chosen by a select input.

Top module: `pswp_delay_meas`

## Requirements
- R1: After reset, `busy`, `lc_launch`, `ps_step_req`, `ps_zero_req` and `delay_valid` are all low.
- R2: With `edge_sel`=0 (rising), every test launches `lc_vec`=0 first and then `lc_vec`=1, and the expected captured value is 1.
- R3: With `edge_sel`=1 (falling), every test launches `lc_vec`=1 first and then `lc_vec`=0, and the expected captured value is 0.
- R4: A test succeeds when `cap_bit` equals the second launched value. `delay_out` then reports the number of phase steps taken before that test, with `delay_timeout`=0.
- R5: `ps_step_req` stays high until `ps_done` is seen. Exactly one step request is made between consecutive tests. No launch occurs while a step request is pending, and `ps_step_req` and `ps_zero_req` are never high together.
- R6: If the test at step `max_step` fails, the result is reported with `delay_timeout`=1 and `delay_out`=`max_step`, and no further steps are requested.
- R7: After a result, `ps_zero_req` is raised in the next cycle and held until `ps_done`; only then does `busy` fall. A `start` pulse while `busy` is high is ignored.
- R8: `delay_valid` is a single-cycle pulse per measurement.
- R9: If the first test at step 0 succeeds, no phase step is requested and `delay_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| edge_sel | input | 1 | 0 measures a rising transition, 1 a falling one |
| max_step | input | STEP_W | Highest phase step index to try |
| cap_bit | input | 1 | Value held by the capture register |
| ps_done | input | 1 | Phase interface acknowledge |
| ps_step_req | output | 1 | Request one fine phase increment |
| ps_zero_req | output | 1 | Request return of the phase to step zero |
| lc_launch | output | 1 | Load the launch register with `lc_vec` |
| lc_vec | output | 1 | Value for the launch register |
| busy | output | 1 | Measurement in progress |
| delay_valid | output | 1 | Result pulse |
| delay_out | output | STEP_W | Phase step index of the result |
| delay_timeout | output | 1 | Result is a timeout |

## Verification
A corrupted step counter shows up at the ports as a `delay_out` that differs from the number of acknowledged step handshakes. This is visible in the result cycle itself. A wrong state-machine state appears within a cycle or two, as a launch during a pending step request, a launch vector in the wrong order, or a missing return-to-zero request after `delay_valid`. A wrong latched edge or limit gives a wrong vector at the very next launch, or a wrong timeout boundary.

// File: rtl/pswp_pkg.sv
`timescale 1ns/1ps
package pswp_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PRESET,
    S_PWAIT,
    S_FIRE,
    S_FWAIT,
    S_STEP,
    S_REPORT,
    S_ZERO
  } pswp_state_e;
endpackage

// File: rtl/pswp_timer.sv
`timescale 1ns/1ps
module pswp_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] LOADV = TW'(SETTLE_CYC);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? LOADV : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0) && !load;
endmodule

// File: rtl/pswp_step_ctr.sv
`timescale 1ns/1ps
module pswp_step_ctr #(
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [STEP_W-1:0] max_in,
  output logic [STEP_W-1:0] count,
  output logic              at_max
);
  logic [STEP_W-1:0] cnt_q, cnt_d, max_q;
  logic              cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      max_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (clr)    max_q <= max_in;
    end
  end

  assign count  = cnt_q;
  assign at_max = (cnt_q == max_q);
endmodule

// File: rtl/pswp_ctrl.sv
`timescale 1ns/1ps
module pswp_ctrl
  import pswp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic edge_sel,
  input  logic cap_bit,
  input  logic ps_done,
  input  logic tmr_done,
  input  logic at_max,
  output logic tmr_load,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic lc_launch,
  output logic lc_vec,
  output logic ps_step_req,
  output logic ps_zero_req,
  output logic busy,
  output logic rpt,
  output logic res_take,
  output logic res_tmo
);
  pswp_state_e st_q, st_d;
  logic        edge_q, edge_en;
  logic        v_first, v_final, hit;

  assign v_first = edge_q;
  assign v_final = ~edge_q;
  assign hit     = (cap_bit == v_final);

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    res_take = 1'b0;
    res_tmo  = 1'b0;
    edge_en  = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        cnt_clr = 1'b1;
        edge_en = 1'b1;
        st_d    = S_PRESET;
      end
      S_PRESET: begin
        tmr_load = 1'b1;
        st_d     = S_PWAIT;
      end
      S_PWAIT: if (tmr_done) st_d = S_FIRE;
      S_FIRE: begin
        tmr_load = 1'b1;
        st_d     = S_FWAIT;
      end
      S_FWAIT: if (tmr_done) begin
        if (hit) begin
          res_take = 1'b1;
          st_d     = S_REPORT;
        end else if (at_max) begin
          res_take = 1'b1;
          res_tmo  = 1'b1;
          st_d     = S_REPORT;
        end else begin
          st_d = S_STEP;
        end
      end
      S_STEP: if (ps_done) begin
        cnt_inc = 1'b1;
        st_d    = S_PRESET;
      end
      S_REPORT: st_d = S_ZERO;
      S_ZERO:   if (ps_done) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      edge_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (edge_en) edge_q <= edge_sel;
    end
  end

  assign lc_launch   = (st_q == S_PRESET) || (st_q == S_FIRE);
  assign lc_vec      = ((st_q == S_PRESET) || (st_q == S_PWAIT)) ? v_first : v_final;
  assign ps_step_req = (st_q == S_STEP);
  assign ps_zero_req = (st_q == S_ZERO);
  assign busy        = (st_q != S_IDLE);
  assign rpt         = (st_q == S_REPORT);
endmodule

// File: rtl/pswp_delay_meas.sv
`timescale 1ns/1ps
module pswp_delay_meas #(
  parameter int STEP_W     = 10,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              edge_sel,
  input  logic [STEP_W-1:0] max_step,
  input  logic              cap_bit,
  input  logic              ps_done,
  output logic              ps_step_req,
  output logic              ps_zero_req,
  output logic              lc_launch,
  output logic              lc_vec,
  output logic              busy,
  output logic              delay_valid,
  output logic [STEP_W-1:0] delay_out,
  output logic              delay_timeout
);
  logic              tmr_load, tmr_done, cnt_clr, cnt_inc, at_max;
  logic              rpt, res_take, res_tmo;
  logic [STEP_W-1:0] count;
  logic [STEP_W-1:0] dly_q, dly_d;
  logic              tmo_q, tmo_d;

  pswp_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done)
  );

  pswp_step_ctr #(.STEP_W(STEP_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .max_in(max_step), .count(count), .at_max(at_max)
  );

  pswp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_sel(edge_sel),
    .cap_bit(cap_bit), .ps_done(ps_done), .tmr_done(tmr_done),
    .at_max(at_max), .tmr_load(tmr_load), .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc), .lc_launch(lc_launch), .lc_vec(lc_vec),
    .ps_step_req(ps_step_req), .ps_zero_req(ps_zero_req), .busy(busy),
    .rpt(rpt), .res_take(res_take), .res_tmo(res_tmo)
  );

  always_comb begin
    dly_d = count;
    tmo_d = res_tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      tmo_q <= 1'b0;
    end else if (res_take) begin
      dly_q <= dly_d;
      tmo_q <= tmo_d;
    end
  end

  assign delay_valid   = rpt;
  assign delay_out     = dly_q;
  assign delay_timeout = tmo_q;
endmodule

// File: rtl/pswp_delay_meas_chk.sv
`timescale 1ns/1ps
module pswp_delay_meas_chk #(
  parameter int STEP_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ps_done,
  input logic              ps_step_req,
  input logic              ps_zero_req,
  input logic              lc_launch,
  input logic              busy,
  input logic              delay_valid,
  input logic [STEP_W-1:0] delay_out
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ps_step_req && !ps_zero_req && !lc_launch && !delay_valid));

  assert_step_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_step_req && !ps_done) |=> ps_step_req);

  assert_no_launch_in_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ps_step_req |-> !lc_launch);

  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ps_step_req && ps_zero_req));

  assert_zero_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    delay_valid |=> ps_zero_req);

  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_zero_req && !ps_done) |=> (ps_zero_req && busy));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    delay_valid |=> !delay_valid);

  assert_result_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_zero_req |-> $stable(delay_out));
endmodule

bind pswp_delay_meas pswp_delay_meas_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ps_done(ps_done), .ps_step_req(ps_step_req),
  .ps_zero_req(ps_zero_req), .lc_launch(lc_launch), .busy(busy),
  .delay_valid(delay_valid), .delay_out(delay_out)
);

// File: tb/sim_pswp_delay_meas.sv
`timescale 1ns/1ps
module sim_pswp_delay_meas;
  localparam int STEP_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              edge_sel = 1'b0;
  logic [STEP_W-1:0] max_step = '0;
  logic              cap_bit = 1'b0;
  logic              ps_done = 1'b0;
  logic              ps_step_req, ps_zero_req, lc_launch, lc_vec, busy;
  logic              delay_valid, delay_timeout;
  logic [STEP_W-1:0] delay_out;

  int n_chk = 0;
  int n_fail = 0;
  int phase = 0;
  int path_d = 0;
  int lat = 0;
  int launch_idx = 0;
  int step_hs = 0;
  int zero_hs = 0;
  int cyc = 0;
  logic cur_edge = 1'b0;
  logic prev_vec = 1'b0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  pswp_delay_meas #(.STEP_W(STEP_W), .SETTLE_CYC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_sel(edge_sel),
    .max_step(max_step), .cap_bit(cap_bit), .ps_done(ps_done),
    .ps_step_req(ps_step_req), .ps_zero_req(ps_zero_req),
    .lc_launch(lc_launch), .lc_vec(lc_vec), .busy(busy),
    .delay_valid(delay_valid), .delay_out(delay_out),
    .delay_timeout(delay_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Behavioural model of path, capture register and phase interface,
  // plus per-cycle protocol checks, all updated away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      check(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
    if (rst_n) begin
      check(!(ps_step_req && ps_zero_req), "R5 exclusive req", ps_step_req, 0);
      if (ps_step_req) check(!lc_launch, "R5 launch during step", lc_launch, 0);
      if (lc_launch) begin
        logic ev;
        ev = (launch_idx % 2 == 0) ? cur_edge : ~cur_edge;
        check(lc_vec == ev, cur_edge ? "R3 launch order" : "R2 launch order", lc_vec, ev);
        launch_idx++;
        cap_bit  = (phase >= path_d) ? lc_vec : prev_vec;
        prev_vec = lc_vec;
      end
      if (ps_done) begin
        ps_done = 1'b0;
        lat     = 0;
      end else if (ps_step_req || ps_zero_req) begin
        lat++;
        if (lat == 2) begin
          ps_done = 1'b1;
          if (ps_step_req) begin
            phase++;
            step_hs++;
          end else begin
            phase = 0;
            zero_hs++;
          end
        end
      end
    end
  end

  task automatic run_meas(input logic e, input int d, input int mx, input bit poke);
    int exp_d;
    bit exp_t;
    int guard;
    exp_t = (d > mx);
    exp_d = exp_t ? mx : d;
    @(negedge clk);
    path_d = d;
    cur_edge = e;
    launch_idx = 0;
    step_hs = 0;
    zero_hs = 0;
    edge_sel = e;
    max_step = STEP_W'(mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!delay_valid && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 3) begin
        edge_sel = ~e;
        max_step = '0;
        start    = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(delay_out == STEP_W'(exp_d), exp_t ? "R6 delay at limit" : "R4 delay value",
          int'(delay_out), exp_d);
    check(delay_timeout == exp_t, exp_t ? "R6 timeout flag" : "R4 timeout flag",
          int'(delay_timeout), int'(exp_t));
    check(step_hs == exp_d, (d == 0) ? "R9 step count" : "R5 step count", step_hs, exp_d);
    check(launch_idx == 2 * (exp_d + 1), "R5 tests per step", launch_idx, 2 * (exp_d + 1));
    @(negedge clk);
    check(!delay_valid, "R8 single pulse", delay_valid, 0);
    check(ps_zero_req, "R7 zero request", ps_zero_req, 1);
    guard = 0;
    while (busy && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check(zero_hs == 1 && phase == 0, "R7 phase returned", phase, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R7 idle after result", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !lc_launch && !ps_step_req && !ps_zero_req && !delay_valid,
          "R1 reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !delay_valid, "R1 idle after release", busy, 0);
    run_meas(1'b0, 3, 10, 1'b0);   // R2 R4 rising
    run_meas(1'b1, 5, 10, 1'b0);   // R3 R4 falling
    run_meas(1'b0, 0, 10, 1'b0);   // R9 immediate success
    run_meas(1'b1, 7, 4, 1'b0);    // R6 timeout
    run_meas(1'b0, 4, 4, 1'b0);    // R4 success exactly at limit
    run_meas(1'b1, 2, 0, 1'b0);    // R6 zero limit
    run_meas(1'b0, 6, 9, 1'b1);    // R7 start ignored while busy
    finish_run();
  end
endmodule